// File: doc/BRIEF.md
# QR Decomposition Operation Sequencer

This block is the control unit of a column-oriented QR solver that shares one multiply/add vector unit and one divide/square-root unit. Given a column count n, it emits the ordered instruction stream for a reordered modified Gram-Schmidt decomposition. Each instruction carries an opcode, a step index k and a column index j, and goes out over a valid/ready handshake into a command FIFO, so issue can run ahead of execution.

The stream has two passes. The first pass uses only squared norms and needs no square root: for each step it takes the self dot product of column k, the dot products of column k with every later column, and then the update of every later column. The second pass takes every square root and final scaling. A result-return strobe from the arithmetic side marks which scalar or column update has finished. A scoreboard records these returns, and an instruction is offered only once everything it reads is ready.

Top module: `qr_op_sequencer`

## Requirements
- R1: After reset, `cmd_valid_o`, `busy_o` and `done_o` are low.
- R2: A `start_i` pulse with `ncols_i` in 1..MAXN while idle latches n, clears the scoreboard, raises `busy_o` and clears `done_o` on the next cycle. A start with n of 0, with n above MAXN, or while busy has no effect.
- R3: Pass one runs for k = 1..n in order. It issues MAG(k) with j = 0, then DOT(k,j) for j = k+1..n, then SUB(k,j) for j = k+1..n.
- R4: Pass two runs for k = 1..n in order. It issues SQRT(k) with j = 0, then DIVS(k,j) for j = k+1..n, then DIVC(k) with j = 0.
- R5: Opcodes on `cmd_op_o` are MAG=0, DOT=1, SUB=2, SQRT=3, DIVS=4, DIVC=5. The k and j fields are 1-based.
- R6: Result kinds on `res_kind_i` are: 0 = squared norm of step k ready, 1 = projection (k,j) ready, 2 = column j updated at step k. Kind 3 and indices outside 1..MAXN are ignored.
- R7: Dependencies for k > 1: MAG(k) needs column k updated at step k-1. DOT(k,j) needs columns k and j updated at step k-1. DIVC(k) needs column k updated at step k-1.
- R8: Further dependencies: SUB(k,j) needs the squared norm k and projection (k,j). SQRT(k) needs the squared norm k. DIVS(k,j) needs projection (k,j). DIVC(k) also needs the squared norm k.
- R9: `cmd_valid_o` is low while a dependency is missing. Once offered while `cmd_ready_i` is low, the instruction stays offered and unchanged until it is accepted.
- R10: `done_o` rises the cycle after DIVC(n) is accepted. At that point `busy_o` and `cmd_valid_o` are low, and `done_o` stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse |
| ncols_i | input | NW | Column count n, sampled with start |
| res_valid_i | input | 1 | Result-return strobe |
| res_kind_i | input | 2 | Kind of returned result |
| res_k_i | input | IDXW | Step index of the returned result |
| res_j_i | input | IDXW | Column index of the returned result |
| cmd_valid_o | output | 1 | Instruction offered |
| cmd_ready_i | input | 1 | FIFO can accept |
| cmd_op_o | output | 3 | Opcode |
| cmd_k_o | output | IDXW | Step index k |
| cmd_j_o | output | IDXW | Column index j, 0 for single-column ops |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |

## Verification
The bench builds the block with MAXN = 6 and IDXW = 8. This puts every legal column count from 1 to 6 within reach of one sweep, and the 3-bit count field can also carry the illegal value 7. The bench acts as the arithmetic side. It returns results late and in pseudo-random gaps, and in one run it withholds them altogether, so every stall rule is exercised against a model scoreboard built from the dependency rules. Back-pressure, a start pulse in mid-run and junk result strobes are mixed into the same sweep.

// File: rtl/qr_seq_pkg.sv
// Shared opcode and result-kind encodings for the QR operation sequencer.
// Assumes the encodings are fixed by the command FIFO consumer.
package qr_seq_pkg;
    typedef enum logic [2:0] {
        OP_MAG  = 3'd0,
        OP_DOT  = 3'd1,
        OP_SUB  = 3'd2,
        OP_SQRT = 3'd3,
        OP_DIVS = 3'd4,
        OP_DIVC = 3'd5
    } qr_op_e;

    typedef enum logic [1:0] {
        RK_NORM2 = 2'd0,
        RK_PROJ  = 2'd1,
        RK_UPD   = 2'd2,
        RK_NONE  = 2'd3
    } res_kind_e;
endpackage

// File: rtl/qr_scoreboard.sv
// Ready bits for squared norms, projections and column updates.
// Bits are set by the result-return strobe and cleared together by clr_i.
// Assumes MAXN >= 2; out-of-range indices and kind 3 are dropped.
module qr_scoreboard
    import qr_seq_pkg::*;
#(
    parameter int MAXN = 16,
    parameter int IDXW = 8
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr_i,
    input  logic                           res_valid_i,
    input  logic [1:0]                     res_kind_i,
    input  logic [IDXW-1:0]                res_k_i,
    input  logic [IDXW-1:0]                res_j_i,
    output logic [MAXN-1:0]                r2_rdy_o,
    output logic [MAXN-1:0][MAXN-1:0]      rn_rdy_o,
    output logic [MAXN-1:0][MAXN-1:0]      upd_rdy_o
);
    localparam int IW = $clog2(MAXN);

    logic          j_ok;
    logic [IW-1:0] jidx;

    // Decode the column index of the incoming result.
    assign j_ok = (res_j_i != '0) && (res_j_i <= IDXW'(MAXN));
    assign jidx = IW'(res_j_i - IDXW'(1));

    for (genvar i = 0; i < MAXN; i++) begin : g_row
        logic            r2_b;
        logic [MAXN-1:0] rn_b;
        logic [MAXN-1:0] upd_b;
        logic            hit;

        assign hit = res_valid_i && (res_k_i == IDXW'(i + 1));

        // Record results that belong to step i+1.
        always_ff @(posedge clk) begin
            if (!rst_n || clr_i) begin
                r2_b  <= 1'b0;
                rn_b  <= '0;
                upd_b <= '0;
            end else if (hit) begin
                case (res_kind_i)
                    RK_NORM2: r2_b <= 1'b1;
                    RK_PROJ:  if (j_ok) rn_b[jidx] <= 1'b1;
                    RK_UPD:   if (j_ok) upd_b[jidx] <= 1'b1;
                    default:  ;
                endcase
            end
        end

        assign r2_rdy_o[i]  = r2_b;
        assign rn_rdy_o[i]  = rn_b;
        assign upd_rdy_o[i] = upd_b;
    end

    // R6: no strobe and no clear leaves every ready bit unchanged
    a_r6_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !res_valid_i) |=> ($stable(r2_rdy_o) && $stable(rn_rdy_o) && $stable(upd_rdy_o)));

    // R6: a kind-3 strobe changes nothing
    a_r6_kind3_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && res_valid_i && res_kind_i == 2'd3)
        |=> ($stable(r2_rdy_o) && $stable(rn_rdy_o) && $stable(upd_rdy_o)));
endmodule

// File: rtl/qr_seq_walker.sv
// Walks the two-pass instruction order: a step counter k, a column counter j
// and the current opcode, which doubles as the phase. Advances on step_i only.
// Assumes n_i is in 1..MAXN when launch_i is high.
module qr_seq_walker
    import qr_seq_pkg::*;
#(
    parameter int MAXN = 16,
    parameter int NW   = $clog2(MAXN + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_i,
    input  logic [NW-1:0] n_i,
    input  logic          step_i,
    output logic          active_o,
    output logic          done_o,
    output qr_op_e        op_o,
    output logic [NW-1:0] k_o,
    output logic [NW-1:0] j_o,
    output logic [NW-1:0] n_o
);
    localparam logic [NW-1:0] ONE = NW'(1);

    logic          active_q, done_q;
    qr_op_e        ph_q;
    logic [NW-1:0] k_q, j_q, n_q;

    // Phase and index update on launch or on each accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            ph_q     <= OP_MAG;
            k_q      <= ONE;
            j_q      <= '0;
            n_q      <= '0;
        end else if (launch_i) begin
            active_q <= 1'b1;
            done_q   <= 1'b0;
            ph_q     <= OP_MAG;
            k_q      <= ONE;
            j_q      <= '0;
            n_q      <= n_i;
        end else if (step_i && active_q) begin
            case (ph_q)
                OP_MAG: begin
                    if (k_q == n_q) begin
                        ph_q <= OP_SQRT;
                        k_q  <= ONE;
                    end else begin
                        ph_q <= OP_DOT;
                        j_q  <= k_q + ONE;
                    end
                end
                OP_DOT: begin
                    if (j_q == n_q) begin
                        ph_q <= OP_SUB;
                        j_q  <= k_q + ONE;
                    end else begin
                        j_q <= j_q + ONE;
                    end
                end
                OP_SUB: begin
                    if (j_q == n_q) begin
                        ph_q <= OP_MAG;
                        k_q  <= k_q + ONE;
                        j_q  <= '0;
                    end else begin
                        j_q <= j_q + ONE;
                    end
                end
                OP_SQRT: begin
                    if (k_q == n_q) begin
                        ph_q <= OP_DIVC;
                    end else begin
                        ph_q <= OP_DIVS;
                        j_q  <= k_q + ONE;
                    end
                end
                OP_DIVS: begin
                    if (j_q == n_q) begin
                        ph_q <= OP_DIVC;
                        j_q  <= '0;
                    end else begin
                        j_q <= j_q + ONE;
                    end
                end
                default: begin
                    if (k_q == n_q) begin
                        active_q <= 1'b0;
                        done_q   <= 1'b1;
                    end else begin
                        ph_q <= OP_SQRT;
                        k_q  <= k_q + ONE;
                    end
                end
            endcase
        end
    end

    assign active_o = active_q;
    assign done_o   = done_q;
    assign op_o     = ph_q;
    assign k_o      = k_q;
    assign j_o      = j_q;
    assign n_o      = n_q;

    // R3: a pair-indexed phase always has j strictly above k and within n
    a_r3_pair_order: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && (ph_q == OP_DOT || ph_q == OP_SUB || ph_q == OP_DIVS))
        |-> (j_q > k_q && j_q <= n_q));

    // R2: a launch makes the walker active next cycle
    a_r2_launch_active: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> (active_q && !done_q));
endmodule

// File: rtl/qr_op_sequencer.sv
// Control unit of a two-pass QR solver. It issues MAG/DOT/SUB in pass one and
// SQRT/DIVS/DIVC in pass two, each gated by scoreboard ready bits.
// Assumes the divide/square-root unit executes its instructions in order,
// so a DIVS or DIVC always follows the SQRT of its own step.
module qr_op_sequencer
    import qr_seq_pkg::*;
#(
    parameter int MAXN = 16,
    parameter int IDXW = 8,
    parameter int NW   = $clog2(MAXN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NW-1:0]   ncols_i,
    input  logic            res_valid_i,
    input  logic [1:0]      res_kind_i,
    input  logic [IDXW-1:0] res_k_i,
    input  logic [IDXW-1:0] res_j_i,
    output logic            cmd_valid_o,
    input  logic            cmd_ready_i,
    output logic [2:0]      cmd_op_o,
    output logic [IDXW-1:0] cmd_k_o,
    output logic [IDXW-1:0] cmd_j_o,
    output logic            busy_o,
    output logic            done_o
);
    localparam int IW = $clog2(MAXN);

    logic                      launch, step, active, fin, first;
    logic                      deps_ok, col_k_done, col_j_done;
    qr_op_e                    op;
    logic [NW-1:0]             wk, wj, wn;
    logic [IW-1:0]             kx, jx, kp;
    logic [MAXN-1:0]           r2_rdy;
    logic [MAXN-1:0][MAXN-1:0] rn_rdy, upd_rdy;

    // Accept a start only when idle and the count is legal.
    assign launch = start_i && !active && (ncols_i != '0) && (ncols_i <= NW'(MAXN));
    assign step   = cmd_valid_o && cmd_ready_i;

    qr_seq_walker #(.MAXN(MAXN), .NW(NW)) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch_i (launch),
        .n_i      (ncols_i),
        .step_i   (step),
        .active_o (active),
        .done_o   (fin),
        .op_o     (op),
        .k_o      (wk),
        .j_o      (wj),
        .n_o      (wn)
    );

    qr_scoreboard #(.MAXN(MAXN), .IDXW(IDXW)) u_score (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (launch),
        .res_valid_i (res_valid_i),
        .res_kind_i  (res_kind_i),
        .res_k_i     (res_k_i),
        .res_j_i     (res_j_i),
        .r2_rdy_o    (r2_rdy),
        .rn_rdy_o    (rn_rdy),
        .upd_rdy_o   (upd_rdy)
    );

    // Zero-based scoreboard indices for the current instruction.
    assign first = (wk == NW'(1));
    assign kx    = IW'(wk - NW'(1));
    assign jx    = IW'(wj - NW'(1));
    assign kp    = first ? '0 : IW'(wk - NW'(2));

    assign col_k_done = first || upd_rdy[kp][kx];
    assign col_j_done = first || upd_rdy[kp][jx];

    // Dependency check for the instruction at the head of the walk.
    always_comb begin
        case (op)
            OP_MAG:  deps_ok = col_k_done;
            OP_DOT:  deps_ok = col_k_done && col_j_done;
            OP_SUB:  deps_ok = r2_rdy[kx] && rn_rdy[kx][jx];
            OP_SQRT: deps_ok = r2_rdy[kx];
            OP_DIVS: deps_ok = rn_rdy[kx][jx];
            default: deps_ok = r2_rdy[kx] && col_k_done;
        endcase
    end

    assign cmd_valid_o = active && deps_ok;
    assign cmd_op_o    = op;
    assign cmd_k_o     = IDXW'(wk);
    assign cmd_j_o     = IDXW'(wj);
    assign busy_o      = active;
    assign done_o      = fin;

    // R9: an offered instruction that is not taken stays offered and unchanged
    a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid_o && !cmd_ready_i)
        |=> (cmd_valid_o && $stable(cmd_op_o) && $stable(cmd_k_o) && $stable(cmd_j_o)));

    // R10: a finished sequence offers nothing and is not busy
    a_r10_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!cmd_valid_o && !busy_o));

    // R5: the step index is 1-based and never beyond the latched count
    a_r5_k_range: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> (cmd_k_o >= IDXW'(1) && cmd_k_o <= IDXW'(wn)));

    // R2: a start while busy does not disturb the pending instruction
    a_r2_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && !step)
        |=> ($stable(cmd_op_o) && $stable(cmd_k_o) && $stable(cmd_j_o)));
endmodule

// File: tb/test_qr_op_sequencer.sv
// Self-checking bench: sweeps n = 1..MAXN, plays the arithmetic units with
// delayed result returns, and checks order, stalls and hand-off.
module test_qr_op_sequencer;
    localparam int MAXN = 6;
    localparam int IDXW = 8;
    localparam int NW   = $clog2(MAXN + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [NW-1:0]   ncols = '0;
    logic            res_valid = 1'b0;
    logic [1:0]      res_kind = 2'd3;
    logic [IDXW-1:0] res_k = '0;
    logic [IDXW-1:0] res_j = '0;
    logic            cmd_valid, cmd_ready = 1'b0;
    logic [2:0]      cmd_op;
    logic [IDXW-1:0] cmd_k, cmd_j;
    logic            busy, done;

    qr_op_sequencer #(.MAXN(MAXN), .IDXW(IDXW)) i_qr_op_sequencer (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ncols_i(ncols),
        .res_valid_i(res_valid), .res_kind_i(res_kind), .res_k_i(res_k), .res_j_i(res_j),
        .cmd_valid_o(cmd_valid), .cmd_ready_i(cmd_ready), .cmd_op_o(cmd_op),
        .cmd_k_o(cmd_k), .cmd_j_o(cmd_j), .busy_o(busy), .done_o(done)
    );

    always #10 clk = ~clk;

    int checks = 0, fails = 0, mon_checks = 0, mon_fails = 0;
    bit finished = 1'b0;
    bit hold = 1'b0, junk_en = 1'b0;
    logic [15:0] lfsr = 16'hACE1;
    int q_kind [0:1023];
    int q_k [0:1023];
    int q_j [0:1023];
    int wr = 0, rd = 0;
    bit m_r2 [0:7];
    bit m_rn [0:7][0:7];
    bit m_upd [0:7][0:7];

    always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Dependency rules R7/R8 over the bench's own record of returned results.
    function automatic bit deps_ok(input int op, input int k, input int j);
        case (op)
            0: return k == 1 || m_upd[k-1][k];
            1: return k == 1 || (m_upd[k-1][k] && m_upd[k-1][j]);
            2: return m_r2[k] && m_rn[k][j];
            3: return m_r2[k];
            4: return m_rn[k][j];
            5: return m_r2[k] && (k == 1 || m_upd[k-1][k]);
            default: return 1'b0;
        endcase
    endfunction

    // Arithmetic-unit stand-in: returns queued results in random gaps.
    always @(negedge clk) begin
        res_valid = 1'b0;
        res_kind  = 2'd3;
        if (hold && junk_en) begin
            res_valid = 1'b1;
            res_kind  = 2'd3;
            res_k     = IDXW'(1);
            res_j     = IDXW'(2);
        end else if (!hold && rd != wr && lfsr[0]) begin
            res_valid = 1'b1;
            res_kind  = 2'(q_kind[rd % 1024]);
            res_k     = IDXW'(q_k[rd % 1024]);
            res_j     = IDXW'(q_j[rd % 1024]);
            case (q_kind[rd % 1024])
                0: m_r2[q_k[rd % 1024]] = 1'b1;
                1: m_rn[q_k[rd % 1024]][q_j[rd % 1024]] = 1'b1;
                default: m_upd[q_k[rd % 1024]][q_j[rd % 1024]] = 1'b1;
            endcase
            rd++;
        end
    end

    // Monitor: any offered instruction must have its inputs returned (R7, R8, R9).
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            mon_checks++;
            if (!deps_ok(int'(cmd_op), int'(cmd_k), int'(cmd_j))) begin
                mon_fails++;
                $display("FAIL R8 offered op %0d k %0d j %0d before its inputs: actual valid 1 expected 0",
                         cmd_op, cmd_k, cmd_j);
            end
        end
    end

    task automatic emit(input int op, input int k, input int j);
        string req;
        req = (op < 3) ? "R3" : "R4";
        while (!cmd_valid) @(negedge clk);
        check(int'(cmd_op) == op, req, "opcode (R5)", int'(cmd_op), op);
        check(int'(cmd_k) == k, req, "k index", int'(cmd_k), k);
        check(int'(cmd_j) == j, req, "j index", int'(cmd_j), j);
        if (lfsr[3]) begin
            @(negedge clk);
            check(cmd_valid && int'(cmd_op) == op && int'(cmd_k) == k && int'(cmd_j) == j,
                  "R9", "held instruction", int'(cmd_k), k);
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        if (op < 3) begin
            q_kind[wr % 1024] = op;
            q_k[wr % 1024]    = k;
            q_j[wr % 1024]    = j;
            wr++;
        end
    endtask

    task automatic run(input int n, input bit stall_test, input bit restart_test);
        while (rd != wr) @(negedge clk);
        for (int a = 0; a < 8; a++) begin
            m_r2[a] = 1'b0;
            for (int b = 0; b < 8; b++) begin
                m_rn[a][b]  = 1'b0;
                m_upd[a][b] = 1'b0;
            end
        end
        hold    = stall_test;
        junk_en = stall_test;
        start = 1'b1;
        ncols = NW'(n);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
        check(done == 1'b0, "R2", "done cleared by start", int'(done), 0);
        for (int k = 1; k <= n; k++) begin
            emit(0, k, 0);
            for (int j = k + 1; j <= n; j++) emit(1, k, j);
            if (stall_test && k == 1) begin
                for (int c = 0; c < 20; c++) begin
                    check(cmd_valid == 1'b0, "R6", "stall under kind-3 strobes", int'(cmd_valid), 0);
                    @(negedge clk);
                end
                hold    = 1'b0;
                junk_en = 1'b0;
            end
            if (restart_test && k == 1) begin
                start = 1'b1;
                ncols = NW'(2);
                @(negedge clk);
                start = 1'b0;
            end
            for (int j = k + 1; j <= n; j++) emit(2, k, j);
        end
        for (int k = 1; k <= n; k++) begin
            emit(3, k, 0);
            for (int j = k + 1; j <= n; j++) emit(4, k, j);
            emit(5, k, 0);
        end
        check(done == 1'b1, "R10", "done after last column divide", int'(done), 1);
        check(busy == 1'b0, "R10", "busy after finish", int'(busy), 0);
        check(cmd_valid == 1'b0, "R10", "valid after finish", int'(cmd_valid), 0);
        repeat (3) @(negedge clk);
        check(done == 1'b1, "R10", "done held", int'(done), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(cmd_valid == 1'b0, "R1", "valid after reset", int'(cmd_valid), 0);
        check(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        check(done == 1'b0, "R1", "done after reset", int'(done), 0);
        start = 1'b1;
        ncols = '0;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R2", "start with n=0 ignored", int'(busy), 0);
        start = 1'b1;
        ncols = NW'(MAXN + 1);
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b0, "R2", "start with n>MAXN ignored", int'(busy), 0);
        for (int n = 1; n <= MAXN; n++) run(n, n == 3, n == 4);
        run(MAXN, 1'b0, 1'b1);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures",
                 checks + mon_checks, fails + mon_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures",
                     checks + mon_checks + 1, fails + mon_fails);
            $finish;
        end
    end
endmodule